// File: doc/BRIEF.md
# Opcode Escape Prefix Decoder

This block takes an instruction byte stream and works out where each opcode ends. It reads one byte per accepted beat. A first byte of 0x0F, 0xF2 or 0xF3 is an escape and says that more opcode bytes follow. After 0xF2 or 0xF3, a second byte of 0x0F adds a third byte. The last byte of each opcode is looked up in a support mask for its class. The block then emits the final byte, a class tag and the address of the instruction's first byte, each for one cycle. A first byte of 0xF4 means halt. On halt the program counter is loaded from the `end_addr` input. After a halt or an unsupported opcode the decoder stops taking bytes until it is reset. ModR/M, displacement and immediate fields are not parsed, and no instruction is executed.

The input uses valid/ready. A byte is consumed on a clock edge where `in_valid` and `in_ready` are both high. The producer must hold `in_byte` steady while `in_valid` is high and `in_ready` is low. `in_ready` is high from reset and drops for good after a halt or illegal result. The result strobe has no back-pressure: the consumer must take it in the cycle it appears. Results show on the registered outputs in the cycle after the final byte is consumed. A beat with valid low leaves the decoder state, the counter and the outputs unchanged, even in the middle of an instruction.

Top module: `opdec_top`

## Requirements
- R1: After reset, `in_ready` is 1, `dec_valid` is 0 and `pc` equals RESET_PC (default 1).
- R2: Each consumed byte that does not halt increases `pc` by exactly one, one cycle after it is consumed.
- R3: A first byte other than 0x0F, 0xF2, 0xF3 or 0xF4 completes an instruction. In the next cycle `dec_valid`=1, `dec_class`=0 and `dec_byte` is that byte. With the default mask, the supported plain bytes are 0x01, 0x90 and 0xC3.
- R4: The pair 0x0F, b completes with `dec_class`=1 and `dec_byte`=b. With the default mask, the supported values of b are 0x84, 0x85 and 0xAF.
- R5: The pair 0xF2, b with b not 0x0F completes with class 2. The pair 0xF3, b with b not 0x0F completes with class 3. With the default masks, only 0xA5 is supported after 0xF2 and only 0xAB after 0xF3.
- R6: 0xF2 0x0F b completes with class 4 and 0xF3 0x0F b with class 5. With the default masks, class 4 supports 0x2C and 0x58, and class 5 supports 0x2A and 0x2C.
- R7: A final byte whose bit is clear in its class mask gives `dec_valid`=1 and `dec_illegal`=1, with that class and byte on the outputs.
- R8: A first byte of 0xF4 gives `dec_valid`=1, `dec_halt`=1 and class 0. In the same cycle `pc` equals the `end_addr` sampled when that byte was consumed.
- R9: From the cycle after a halt or illegal result, `in_ready` stays 0 until reset. Bytes offered in that time change neither `pc` nor the outputs.
- R10: `dec_addr` with each result is the `pc` value that the instruction's first byte was fetched from.
- R11: A cycle with `in_valid` low consumes nothing. Inside a multi-byte instruction it neither completes the instruction nor moves `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Instruction byte |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Decoder can consume a byte |
| end_addr | input | ADDR_W | Counter value loaded on halt |
| pc | output | ADDR_W | Fetch address of the next byte |
| dec_valid | output | 1 | One-cycle result strobe |
| dec_class | output | 3 | 0 plain, 1 0x0F, 2 0xF2, 3 0xF3, 4 0xF2 0x0F, 5 0xF3 0x0F |
| dec_byte | output | 8 | Final opcode byte |
| dec_addr | output | ADDR_W | Address of the instruction's first byte |
| dec_halt | output | 1 | Result is a halt |
| dec_illegal | output | 1 | Final byte not supported by its class |

## Verification
Supported opcodes are sent in every class, both as back-to-back beats and with idle beats between the bytes. This shows that the escape states hold across stalls and that the result address follows the first byte, not the last. Unsupported final bytes are sent in several classes, each in a separate run after reset. This separates the per-class mask lookup from the class tag, because the same byte value can be legal in one class and illegal in another. A halt with a non-trivial end address, and bytes offered after a halt or illegal result, check the counter load and the locked input.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int NUM_CLS = 6;
  localparam int TBL_N   = 256;

  typedef enum logic [2:0] {
    CLS_PLAIN = 3'd0,
    CLS_X0F   = 3'd1,
    CLS_P2    = 3'd2,
    CLS_P3    = 3'd3,
    CLS_P2X   = 3'd4,
    CLS_P3X   = 3'd5
  } opcls_e;

  typedef enum logic [2:0] {
    ST_FIRST,
    ST_ESC,
    ST_PF2,
    ST_PF3,
    ST_PF2ESC,
    ST_PF3ESC
  } dstate_e;

  localparam logic [7:0] BYTE_HALT = 8'hF4;
  localparam logic [7:0] BYTE_ESC  = 8'h0F;
  localparam logic [7:0] BYTE_PFX2 = 8'hF2;
  localparam logic [7:0] BYTE_PFX3 = 8'hF3;
endpackage

// File: rtl/opdec_seq.sv
module opdec_seq
  import opdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] cur_byte,
  output logic       at_first,
  output logic       done,
  output logic       is_halt,
  output opcls_e     cls
);
  dstate_e st, st_nxt;

  always_comb begin
    st_nxt  = st;
    done    = 1'b0;
    is_halt = 1'b0;
    cls     = CLS_PLAIN;
    unique case (st)
      ST_FIRST: begin
        if (cur_byte == BYTE_ESC)       st_nxt = ST_ESC;
        else if (cur_byte == BYTE_PFX2) st_nxt = ST_PF2;
        else if (cur_byte == BYTE_PFX3) st_nxt = ST_PF3;
        else begin
          done    = 1'b1;
          is_halt = (cur_byte == BYTE_HALT);
          cls     = CLS_PLAIN;
        end
      end
      ST_ESC: begin
        done   = 1'b1;
        cls    = CLS_X0F;
        st_nxt = ST_FIRST;
      end
      ST_PF2: begin
        if (cur_byte == BYTE_ESC) st_nxt = ST_PF2ESC;
        else begin
          done   = 1'b1;
          cls    = CLS_P2;
          st_nxt = ST_FIRST;
        end
      end
      ST_PF3: begin
        if (cur_byte == BYTE_ESC) st_nxt = ST_PF3ESC;
        else begin
          done   = 1'b1;
          cls    = CLS_P3;
          st_nxt = ST_FIRST;
        end
      end
      ST_PF2ESC: begin
        done   = 1'b1;
        cls    = CLS_P2X;
        st_nxt = ST_FIRST;
      end
      ST_PF3ESC: begin
        done   = 1'b1;
        cls    = CLS_P3X;
        st_nxt = ST_FIRST;
      end
      default: st_nxt = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= ST_FIRST;
    else if (take) st <= st_nxt;
  end

  assign at_first = (st == ST_FIRST);
endmodule

// File: rtl/opdec_table.sv
module opdec_table
  import opdec_pkg::*;
#(
  parameter logic [TBL_N-1:0] MASK_PLAIN = '0,
  parameter logic [TBL_N-1:0] MASK_X0F   = '0,
  parameter logic [TBL_N-1:0] MASK_P2    = '0,
  parameter logic [TBL_N-1:0] MASK_P3    = '0,
  parameter logic [TBL_N-1:0] MASK_P2X   = '0,
  parameter logic [TBL_N-1:0] MASK_P3X   = '0
) (
  input  opcls_e     cls,
  input  logic [7:0] cur_byte,
  output logic       hit
);
  logic [NUM_CLS-1:0][TBL_N-1:0] tbl;
  logic [NUM_CLS-1:0]            hit_v;

  assign tbl[CLS_PLAIN] = MASK_PLAIN;
  assign tbl[CLS_X0F]   = MASK_X0F;
  assign tbl[CLS_P2]    = MASK_P2;
  assign tbl[CLS_P3]    = MASK_P3;
  assign tbl[CLS_P2X]   = MASK_P2X;
  assign tbl[CLS_P3X]   = MASK_P3X;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign hit_v[c] = tbl[c][cur_byte];
  end

  always_comb begin
    hit = 1'b0;
    for (int c = 0; c < NUM_CLS; c++)
      if (cls == opcls_e'(c)) hit = hit_v[c];
  end
endmodule

// File: rtl/opdec_pc.sv
module opdec_pc #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              jump,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              mark,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] start_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      start_addr <= RESET_PC;
    end else begin
      if (jump)      pc <= jump_addr;
      else if (step) pc <= pc + 1'b1;
      if (mark)      start_addr <= pc;
    end
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_PC   = 1,
  parameter logic [TBL_N-1:0]  MASK_PLAIN = (256'd1 << 8'h01) | (256'd1 << 8'h90) | (256'd1 << 8'hC3),
  parameter logic [TBL_N-1:0]  MASK_X0F   = (256'd1 << 8'h84) | (256'd1 << 8'h85) | (256'd1 << 8'hAF),
  parameter logic [TBL_N-1:0]  MASK_P2    = (256'd1 << 8'hA5),
  parameter logic [TBL_N-1:0]  MASK_P3    = (256'd1 << 8'hAB),
  parameter logic [TBL_N-1:0]  MASK_P2X   = (256'd1 << 8'h2C) | (256'd1 << 8'h58),
  parameter logic [TBL_N-1:0]  MASK_P3X   = (256'd1 << 8'h2A) | (256'd1 << 8'h2C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] pc,
  output logic              dec_valid,
  output logic [2:0]        dec_class,
  output logic [7:0]        dec_byte,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              dec_halt,
  output logic              dec_illegal
);
  logic   take, at_first, done, is_halt, hit, stopped;
  logic   finish, bad;
  opcls_e cls;
  logic [ADDR_W-1:0] start_addr;

  assign in_ready = !stopped;
  assign take     = in_valid && in_ready;
  assign finish   = take && done;
  assign bad      = !is_halt && !hit;

  opdec_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .cur_byte (in_byte),
    .at_first (at_first),
    .done     (done),
    .is_halt  (is_halt),
    .cls      (cls)
  );

  opdec_table #(
    .MASK_PLAIN (MASK_PLAIN),
    .MASK_X0F   (MASK_X0F),
    .MASK_P2    (MASK_P2),
    .MASK_P3    (MASK_P3),
    .MASK_P2X   (MASK_P2X),
    .MASK_P3X   (MASK_P3X)
  ) u_tbl (
    .cls      (cls),
    .cur_byte (in_byte),
    .hit      (hit)
  );

  opdec_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (take && !(done && is_halt)),
    .jump       (finish && is_halt),
    .jump_addr  (end_addr),
    .mark       (take && at_first),
    .pc         (pc),
    .start_addr (start_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped     <= 1'b0;
      dec_valid   <= 1'b0;
      dec_class   <= '0;
      dec_byte    <= '0;
      dec_addr    <= RESET_PC;
      dec_halt    <= 1'b0;
      dec_illegal <= 1'b0;
    end else begin
      dec_valid   <= finish;
      dec_halt    <= finish && is_halt;
      dec_illegal <= finish && bad;
      if (finish) begin
        dec_class <= cls;
        dec_byte  <= in_byte;
        dec_addr  <= at_first ? pc : start_addr;
        if (is_halt || bad) stopped <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] end_addr,
  input logic [ADDR_W-1:0] pc,
  input logic              dec_valid,
  input logic [2:0]        dec_class,
  input logic              dec_halt,
  input logic              dec_illegal
);
  a_r9_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !in_ready);

  a_r9_lock_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_halt || dec_illegal) |-> !in_ready);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (pc == $past(pc) + 1'b1) || dec_halt);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(pc));

  a_r8_halt_pc: assert property (@(posedge clk) disable iff (!rst_n)
    dec_halt |-> pc == $past(end_addr));

  a_r7_flags_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_halt || dec_illegal) |-> dec_valid && !(dec_halt && dec_illegal));

  a_r3_class_range: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_class <= 3'd5);

  a_r8_halt_plain: assert property (@(posedge clk) disable iff (!rst_n)
    dec_halt |-> dec_class == 3'd0);
endmodule

bind opdec_top opdec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .end_addr    (end_addr),
  .pc          (pc),
  .dec_valid   (dec_valid),
  .dec_class   (dec_class),
  .dec_halt    (dec_halt),
  .dec_illegal (dec_illegal)
);

// File: tb/tb_opdec_top.sv
module tb_opdec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] end_addr = 32'h0000_4000;
  logic [31:0] pc, dec_addr;
  logic        dec_valid, dec_halt, dec_illegal;
  logic [2:0]  dec_class;
  logic [7:0]  dec_byte;

  int total = 0;
  int bad = 0;

  opdec_top dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .end_addr(end_addr), .pc(pc),
    .dec_valid(dec_valid), .dec_class(dec_class), .dec_byte(dec_byte),
    .dec_addr(dec_addr), .dec_halt(dec_halt), .dec_illegal(dec_illegal)
  );

  always #10 clk = ~clk;

  function automatic bit supported(int c, logic [7:0] b);
    case (c)
      0: return b == 8'h01 || b == 8'h90 || b == 8'hC3;
      1: return b == 8'h84 || b == 8'h85 || b == 8'hAF;
      2: return b == 8'hA5;
      3: return b == 8'hAB;
      4: return b == 8'h2C || b == 8'h58;
      5: return b == 8'h2A || b == 8'h2C;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int          m_st = 0;
  logic [31:0] m_pc = 32'd1, m_start = 32'd1;
  bit          m_dead = 1'b0;
  bit          e_v, e_h, e_i;
  int          e_c;
  logic [7:0]  e_b;
  logic [31:0] e_a;

  always @(posedge clk) begin
    bit fin;
    int c;
    logic [7:0] b;
    e_v = 0; e_h = 0; e_i = 0;
    if (!rst_n) begin
      m_st = 0; m_pc = 32'd1; m_start = 32'd1; m_dead = 0;
    end else if (in_valid && !m_dead) begin
      b = in_byte; fin = 0; c = 0;
      case (m_st)
        0: begin
          m_start = m_pc;
          if (b == 8'h0F) m_st = 1;
          else if (b == 8'hF2) m_st = 2;
          else if (b == 8'hF3) m_st = 3;
          else begin fin = 1; c = 0; end
        end
        1: begin fin = 1; c = 1; end
        2: if (b == 8'h0F) m_st = 4; else begin fin = 1; c = 2; end
        3: if (b == 8'h0F) m_st = 5; else begin fin = 1; c = 3; end
        4: begin fin = 1; c = 4; end
        default: begin fin = 1; c = 5; end
      endcase
      if (fin) begin
        m_st = 0; e_v = 1; e_c = c; e_b = b; e_a = m_start;
        if (c == 0 && b == 8'hF4) e_h = 1;
        else if (!supported(c, b)) e_i = 1;
        m_dead = e_h || e_i;
        m_pc = e_h ? end_addr : m_pc + 1;
      end else begin
        m_pc = m_pc + 1;
      end
    end
    #5;
    if (rst_n) begin
      check(in_ready == !m_dead, "R9 in_ready", in_ready, !m_dead);
      check(pc == m_pc, e_h ? "R8 pc" : "R2 pc", pc, m_pc);
      check(dec_valid == e_v, "R3 dec_valid", dec_valid, e_v);
      check(dec_halt == e_h, "R8 dec_halt", dec_halt, e_h);
      check(dec_illegal == e_i, "R7 dec_illegal", dec_illegal, e_i);
      if (e_v) begin
        check(dec_class == e_c,
              e_c == 0 ? "R3 class" : e_c == 1 ? "R4 class" : e_c < 4 ? "R5 class" : "R6 class",
              dec_class, e_c);
        check(dec_byte == e_b, "R3 dec_byte", dec_byte, e_b);
        check(dec_addr == e_a, "R10 dec_addr", dec_addr, e_a);
      end
    end
  end

  task automatic beat(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
  endtask
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b0; in_byte = 8'hEE;
    end
  endtask
  task automatic do_reset();
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    check(dec_valid === 1'b0, "R1 dec_valid", dec_valid, 0);
    check(pc === 32'd1, "R1 pc", pc, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] hold_pc;
    do_reset();
    // R3 back-to-back plain ops
    beat(8'h90); beat(8'h01); beat(8'hC3); gap(1);
    // R4, R5, R6 with and without gaps
    beat(8'h0F); beat(8'h84); gap(1);
    beat(8'h0F); gap(2); beat(8'hAF);
    beat(8'hF2); beat(8'hA5);
    beat(8'hF3); beat(8'hAB);
    beat(8'hF2); beat(8'h0F); beat(8'h58);
    beat(8'hF3); gap(1); beat(8'h0F); gap(1); beat(8'h2A);
    // R11: stall inside a prefix sequence
    beat(8'hF2); gap(1);
    hold_pc = pc;
    gap(3);
    check(pc == hold_pc, "R11 pc held", pc, hold_pc);
    check(dec_valid == 1'b0, "R11 no result", dec_valid, 0);
    beat(8'h0F); beat(8'h2C); gap(2);
    // R7 illegal in 0F class, then R9 ignored bytes
    beat(8'h0F); beat(8'h2C); gap(1);
    hold_pc = pc;
    beat(8'h90); beat(8'hF4); gap(2);
    check(pc == hold_pc, "R9 pc frozen", pc, hold_pc);
    check(in_ready == 1'b0, "R9 still locked", in_ready, 0);
    // R7 illegal in F3 0F class (0x58 legal only after F2 0F)
    do_reset();
    beat(8'hF3); beat(8'h0F); beat(8'h58); gap(2);
    // R7 plain illegal
    do_reset();
    beat(8'h90); beat(8'h55); gap(2);
    // R7 illegal after F2
    do_reset();
    beat(8'hF2); beat(8'hF2); gap(2);
    // R8 halt after a few ops
    do_reset();
    end_addr = 32'h0000_ABC0;
    beat(8'hC3); beat(8'hF2); beat(8'hA5); beat(8'hF4);
    gap(1);
    check(dec_halt == 1'b1, "R8 halt seen", dec_halt, 1);
    check(pc == 32'h0000_ABC0, "R8 pc loaded", pc, 32'h0000_ABC0);
    beat(8'h90); gap(2);
    check(pc == 32'h0000_ABC0, "R9 pc after halt", pc, 32'h0000_ABC0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule